// File: doc/BRIEF.md
# Adaptive Median Selection Stage

This block is the decision stage of a two-level adaptive median filter for 8-bit greyscale video. Two median engines work side by side on the same pixel stream: a small one with a 3x3 window and a large one with a 5x5 window. Each engine reports the minimum, maximum and median of its window. The small engine also passes the pixel at the window centre. The stage merges these results into one filtered pixel per input pixel.

The large engine finishes later than the small one. The stage therefore holds the small-window statistics and the centre pixel in a delay line whose depth equals the latency gap. Each pixel then meets its own large-window statistics. A rule chain tests the small window first and falls back to the large window. The result is registered and leaves one clock after alignment. A pixel enters on every clock on which `in_valid` is high, and no back-pressure exists.

Top module: `amf_select_stage`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `out_valid` is low.
- R2: `out_valid` is `in_valid` delayed by exactly `LAT_GAP + 1` clocks. A new pixel can be accepted on every clock.
- R3: If the small minimum is strictly below the centre and the centre is strictly below the small maximum, the output is the centre pixel.
- R4: If R3 does not apply, and the small minimum is strictly below the small median and the small median is strictly below the small maximum, the output is the small median.
- R5: If R3 and R4 do not apply, and the large minimum is strictly below the centre and the centre is strictly below the large maximum, the output is the centre pixel.
- R6: If R3 to R5 do not apply, and the large median lies strictly between the large minimum and the large maximum, the output is the large median.
- R7: If none of the tests in R3 to R6 applies, the output is the large median.
- R8: Every comparison is strict. A centre or median that equals a minimum or a maximum fails that test.
- R9: The large statistics presented `LAT_GAP` clocks after a pixel's `in_valid` cycle are the ones combined with that pixel. This holds for back-to-back pixels as well.
- R10: When `out_valid` is low, `out_pix` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the centre pixel and the small-window statistics |
| in_centre | input | PIX_W | Pixel at the window centre |
| sm_min | input | PIX_W | 3x3 window minimum |
| sm_max | input | PIX_W | 3x3 window maximum |
| sm_med | input | PIX_W | 3x3 window median |
| lg_min | input | PIX_W | 5x5 window minimum, arriving LAT_GAP clocks after its pixel |
| lg_max | input | PIX_W | 5x5 window maximum, arriving LAT_GAP clocks after its pixel |
| lg_med | input | PIX_W | 5x5 window median, arriving LAT_GAP clocks after its pixel |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | PIX_W | Filtered pixel |

## Verification
The bench builds the stage with `PIX_W = 8` and `LAT_GAP = 3`. This gap is deep enough to test the alignment. A slip of one stage in the delay line would pair a pixel with a neighbour's large-window statistics, and the generated burst would expose it. Directed pixels drive each branch of the rule chain, including values equal to the minimum or maximum. A run of back-to-back pixels with idle gaps checks the timing of `out_valid` and the zero output between pixels.

// File: rtl/amf_pkg.sv
package amf_pkg;

    // Which rule of the chain produced the output pixel.
    typedef enum logic [2:0] {
        PICK_CENTRE_SM,
        PICK_MED_SM,
        PICK_CENTRE_LG,
        PICK_MED_LG,
        PICK_FALLBACK
    } pick_e;

endpackage

// File: rtl/amf_delay_line.sv
module amf_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_bypass
            assign q = d;
        end else begin : g_shift
            logic [W-1:0] stage [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end

            assign q = stage[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/amf_rule.sv
module amf_rule
    import amf_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] centre,
    input  logic [PIX_W-1:0] s_min,
    input  logic [PIX_W-1:0] s_max,
    input  logic [PIX_W-1:0] s_med,
    input  logic [PIX_W-1:0] l_min,
    input  logic [PIX_W-1:0] l_max,
    input  logic [PIX_W-1:0] l_med,
    output pick_e            pick
);

    logic c_in_sm, m_in_sm, c_in_lg, m_in_lg;

    always_comb begin
        c_in_sm = (s_min < centre) && (centre < s_max);
        m_in_sm = (s_min < s_med)  && (s_med  < s_max);
        c_in_lg = (l_min < centre) && (centre < l_max);
        m_in_lg = (l_min < l_med)  && (l_med  < l_max);

        if (c_in_sm)      pick = PICK_CENTRE_SM;
        else if (m_in_sm) pick = PICK_MED_SM;
        else if (c_in_lg) pick = PICK_CENTRE_LG;
        else if (m_in_lg) pick = PICK_MED_LG;
        else              pick = PICK_FALLBACK;
    end

endmodule

// File: rtl/amf_select_stage.sv
module amf_select_stage
    import amf_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int LAT_GAP = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_centre,
    input  logic [PIX_W-1:0] sm_min,
    input  logic [PIX_W-1:0] sm_max,
    input  logic [PIX_W-1:0] sm_med,
    input  logic [PIX_W-1:0] lg_min,
    input  logic [PIX_W-1:0] lg_max,
    input  logic [PIX_W-1:0] lg_med,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);

    localparam int BUNDLE_W = 1 + 4 * PIX_W;

    logic [BUNDLE_W-1:0] bundle_in, bundle_al;
    logic                al_valid;
    logic [PIX_W-1:0]    al_centre, al_min, al_max, al_med;
    pick_e               pick;

    // Small-window results and the centre wait for the large engine.
    assign bundle_in = {in_valid, in_centre, sm_min, sm_max, sm_med};

    amf_delay_line #(
        .W     (BUNDLE_W),
        .DEPTH (LAT_GAP)
    ) u_align (
        .clk (clk),
        .rst (rst),
        .d   (bundle_in),
        .q   (bundle_al)
    );

    assign {al_valid, al_centre, al_min, al_max, al_med} = bundle_al;

    amf_rule #(
        .PIX_W (PIX_W)
    ) u_rule (
        .centre (al_centre),
        .s_min  (al_min),
        .s_max  (al_max),
        .s_med  (al_med),
        .l_min  (lg_min),
        .l_max  (lg_max),
        .l_med  (lg_med),
        .pick   (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= al_valid;
            if (!al_valid) begin
                out_pix <= '0;
            end else begin
                unique case (pick)
                    PICK_CENTRE_SM: out_pix <= al_centre;
                    PICK_MED_SM:    out_pix <= al_med;
                    PICK_CENTRE_LG: out_pix <= al_centre;
                    PICK_MED_LG:    out_pix <= lg_med;
                    PICK_FALLBACK:  out_pix <= lg_med;
                    default:        out_pix <= lg_med;
                endcase
            end
        end
    end

endmodule

// File: rtl/amf_select_stage_chk.sv
module amf_select_stage_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             al_valid,
    input logic [PIX_W-1:0] al_centre,
    input logic [PIX_W-1:0] al_min,
    input logic [PIX_W-1:0] al_max,
    input logic [PIX_W-1:0] al_med,
    input logic [PIX_W-1:0] lg_min,
    input logic [PIX_W-1:0] lg_max,
    input logic [PIX_W-1:0] lg_med,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix
);

    logic sm_c_ok, sm_m_ok, lg_c_ok, lg_m_ok;
    assign sm_c_ok = (al_min < al_centre) && (al_centre < al_max);
    assign sm_m_ok = (al_min < al_med) && (al_med < al_max);
    assign lg_c_ok = (lg_min < al_centre) && (al_centre < lg_max);
    assign lg_m_ok = (lg_min < lg_med) && (lg_med < lg_max);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        al_valid |=> out_valid);

    assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !al_valid |=> !out_valid);

    assert_centre_small_R3: assert property (@(posedge clk) disable iff (rst)
        (al_valid && sm_c_ok) |=> (out_pix == $past(al_centre)));

    assert_median_small_R4: assert property (@(posedge clk) disable iff (rst)
        (al_valid && !sm_c_ok && sm_m_ok) |=> (out_pix == $past(al_med)));

    assert_centre_large_R5: assert property (@(posedge clk) disable iff (rst)
        (al_valid && !sm_c_ok && !sm_m_ok && lg_c_ok) |=> (out_pix == $past(al_centre)));

    assert_large_median_R7: assert property (@(posedge clk) disable iff (rst)
        (al_valid && !sm_c_ok && !sm_m_ok && !lg_c_ok) |=> (out_pix == $past(lg_med)));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_pix == '0));

endmodule

bind amf_select_stage amf_select_stage_chk #(
    .PIX_W (PIX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .al_valid  (al_valid),
    .al_centre (al_centre),
    .al_min    (al_min),
    .al_max    (al_max),
    .al_med    (al_med),
    .lg_min    (lg_min),
    .lg_max    (lg_max),
    .lg_med    (lg_med),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/test_amf_select_stage.sv
`timescale 1ns/1ps
module test_amf_select_stage;

    localparam int GAP = 3;
    localparam int NV  = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_centre = '0, sm_min = '0, sm_max = '0, sm_med = '0;
    logic [7:0] lg_min = '0, lg_max = '0, lg_med = '0;
    logic       out_valid;
    logic [7:0] out_pix;

    always #5 clk = ~clk;

    amf_select_stage #(.PIX_W(8), .LAT_GAP(GAP)) i_amf_select_stage (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_centre (in_centre),
        .sm_min (sm_min), .sm_max (sm_max), .sm_med (sm_med),
        .lg_min (lg_min), .lg_max (lg_max), .lg_med (lg_med),
        .out_valid (out_valid), .out_pix (out_pix)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;
    bit monitor_on = 1'b0;

    logic       vv [NV];
    logic [7:0] vc [NV], va [NV], vb [NV], vm [NV], wa [NV], wb [NV], wm [NV];
    string      vtag [NV];

    logic [7:0] exp_q [$];
    int         cyc_q [$];
    string      tag_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Rule chain of R3..R8, written from the requirements.
    function automatic logic [7:0] model(input logic [7:0] c, a, b, m, x, y, n);
        if (a < c && c < b)      return c;
        else if (a < m && m < b) return m;
        else if (x < c && c < y) return c;
        else                     return n;
    endfunction

    task automatic set_vec(input int i, input logic v, input logic [7:0] c, a, b, m, x, y, n,
                           input string t);
        vv[i] = v; vc[i] = c; va[i] = a; vb[i] = b; vm[i] = m;
        wa[i] = x; wb[i] = y; wm[i] = n; vtag[i] = t;
    endtask

    // Driver: pushes the expected pixel as it presents each input.
    task automatic drive_cycle(input int k);
        @(negedge clk);
        if (k < NV && vv[k]) begin
            in_valid = 1'b1; in_centre = vc[k]; sm_min = va[k]; sm_max = vb[k]; sm_med = vm[k];
            exp_q.push_back(model(vc[k], va[k], vb[k], vm[k], wa[k], wb[k], wm[k]));
            cyc_q.push_back(cyc);
            tag_q.push_back(vtag[k]);
        end else begin
            in_valid = 1'b0; in_centre = '0; sm_min = '0; sm_max = '0; sm_med = '0;
        end
        if (k - GAP >= 0 && k - GAP < NV) begin
            lg_min = wa[k-GAP]; lg_max = wb[k-GAP]; lg_med = wm[k-GAP];
        end else begin
            lg_min = '0; lg_max = '0; lg_med = '0;
        end
    endtask

    // Monitor: pops and compares as results appear.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected out_valid", 1, 0);
                end else begin
                    logic [7:0] e;
                    int         c0;
                    string      t;
                    e  = exp_q.pop_front();
                    c0 = cyc_q.pop_front();
                    t  = tag_q.pop_front();
                    check(out_pix == e, t, out_pix, e);
                    check(cyc == c0 + GAP + 1, "R2 latency", cyc - c0, GAP + 1);
                end
            end else begin
                check(out_pix == 8'd0, "R10 idle output", out_pix, 0);
            end
        end
    end

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [7:0]  p, q, r, t0, lo, md, hi, c;
        // Directed pixels: centre, small(min,max,med), large(min,max,med)
        set_vec(0, 1, 100, 50, 200, 90, 0, 255, 120, "R3 centre inside small window");
        set_vec(1, 1, 255, 10, 255, 40, 0, 255, 7, "R4 small median");
        set_vec(2, 1, 10, 10, 80, 30, 0, 255, 9, "R8 centre equals small min");
        set_vec(3, 1, 60, 60, 90, 90, 20, 200, 75, "R5 centre inside large window");
        set_vec(4, 1, 0, 0, 255, 255, 0, 255, 128, "R6 large median");
        set_vec(5, 1, 255, 255, 255, 255, 3, 255, 3, "R7 all tests fail");
        set_vec(6, 1, 40, 40, 200, 40, 40, 220, 220, "R8 equal at max, fallback");
        set_vec(7, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        set_vec(8, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
        s = 32'h1234_5678;
        for (int i = 9; i < NV; i++) begin
            s = s * 32'd1103515245 + 32'd12345; p = s[31:24]; q = s[23:16]; r = s[15:8];
            if (p > q) begin t0 = p; p = q; q = t0; end
            if (q > r) begin t0 = q; q = r; r = t0; end
            if (p > q) begin t0 = p; p = q; q = t0; end
            s = s * 32'd1103515245 + 32'd12345;
            c  = s[31:24];
            lo = (p > {4'd0, s[19:16]}) ? p - {4'd0, s[19:16]} : 8'd0;
            hi = (r < 8'd255 - {4'd0, s[15:12]}) ? r + {4'd0, s[15:12]} : 8'd255;
            md = s[11:4];
            if (md < lo) md = lo;
            if (md > hi) md = hi;
            set_vec(i, (i % 11) != 0, c, p, r, q, lo, hi, md, "R9 burst pixel");
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after release", out_valid, 0);
        monitor_on = 1'b1;
        for (int k = 0; k < NV + GAP; k++) drive_cycle(k);
        repeat (GAP + 4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all pixels emerged", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule